// File: doc/BRIEF.md
# Instruction-Boundary Trace and Exception Sequencer

This block sits where a small processor core finishes an instruction. At that point it decides which exceptions must be taken before the next instruction may start. It then issues them one at a time, in a fixed order of precedence. Its inputs are:

- a retire strobe, with flags describing how the instruction ended;
- the two trace-control bits taken from the status register;
- a pending interrupt level with an optional supplied vector;
- a pending breakpoint flag.

For each exception it issues, the block presents a stack record: the address of the instruction that ended, the vector offset, the address of the next instruction and a copy of the status register. Outside logic writes this record to memory.

Trace is raised only for instructions that really executed and completed normally. An instruction aborted by a bus or address fault is not traced at the abort. It is traced when it is restarted and completes normally. A return from such a fault is never traced. An instruction that was refused as illegal, unimplemented or privileged is never traced. A stop-type instruction that is traced does not enter the stopped state, and execution continues after it.

The block holds the core off the next instruction while exceptions are still being issued. It ignores retire strobes during that time, so the entry into a trace handler can never itself be traced.

Top module: `trace_exc_seq`

## Requirements
- R1: After reset, `exc_take`, `hold_next`, `stop_enter` and `trc_rsv_err` are all 0.
- R2: Trace-control code 2'b10 traces every executed instruction. Code 2'b01 traces only those that assert `retire_flow`. Code 2'b00 traces none. A trace is issued with `exc_kind` 2'b01 and vector 9 (offset 0x24). Its record carries `retire_pc`, `next_pc` and `sr_in` as they were at the boundary.
- R3: Trace-control code 2'b11 never causes a trace. It raises `trc_rsv_err` for one cycle, one cycle after the boundary.
- R4: An instruction ended by `fault_abort`, or a return flagged `rte_fault`, is not traced. The same instruction retired again without those flags is traced.
- R5: An instruction flagged `not_executed` is never traced. If it also raises `forced_exc`, only the forced exception is issued.
- R6: A forced exception (`exc_kind` 2'b00, vector `forced_vec`) is issued before the trace of the same instruction.
- R7: A trace is issued before an interrupt (`exc_kind` 2'b10, pending when `irq_level` is nonzero). The interrupt vector is `irq_vec` when that value is 64 or more. Otherwise it is the autovector 24 plus `irq_level`.
- R8: A breakpoint (`exc_kind` 2'b11, vector 12) is issued after any trace and after any interrupt taken at the same boundary.
- R9: A stop-type instruction that is traced takes the trace and leaves `stop_enter` at 0. A stop-type instruction that is not traced pulses `stop_enter` for one cycle, one cycle after the boundary.
- R10: The exceptions from one boundary are issued one per cycle on consecutive cycles, the first two cycles after the boundary edge. `hold_next` is high from the cycle after the boundary until the cycle of the last issue. Retire strobes while `hold_next` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| retire_vld | input | 1 | Instruction reached its completion boundary |
| retire_pc | input | AW | Address of the completing instruction |
| next_pc | input | AW | Address of the next instruction to execute |
| sr_in | input | 16 | Status register value at the boundary |
| trc_mode | input | 2 | Trace-control bits: 00 off, 01 flow only, 10 all, 11 reserved |
| retire_flow | input | 1 | Instruction changed the flow of control |
| forced_exc | input | 1 | Instruction forces an exception |
| forced_vec | input | 8 | Vector of the forced exception |
| fault_abort | input | 1 | Instruction aborted by bus or address fault |
| rte_fault | input | 1 | Return resuming from a fault frame |
| not_executed | input | 1 | Illegal, unimplemented or privileged, not executed |
| stop_insn | input | 1 | Stop-type instruction |
| irq_level | input | 3 | Pending interrupt level, 0 means none |
| irq_vec | input | 8 | Vector supplied with the interrupt |
| bkpt_pend | input | 1 | Breakpoint pending |
| exc_take | output | 1 | An exception is issued this cycle |
| exc_kind | output | 2 | 00 forced, 01 trace, 10 interrupt, 11 breakpoint |
| exc_vec | output | 8 | Vector number |
| stk_vec_off | output | 10 | Vector offset (vector times 4) |
| stk_insn_addr | output | AW | Stacked address of the completing instruction |
| stk_pc | output | AW | Stacked next-instruction address |
| stk_sr | output | 16 | Stacked status register copy |
| hold_next | output | 1 | Next instruction must not start |
| stop_enter | output | 1 | Enter the stopped state |
| trc_rsv_err | output | 1 | Reserved trace-control code seen |

## Verification
The boundary is the rising edge that samples `retire_vld`. `stop_enter`, `trc_rsv_err` and the first rise of `hold_next` are registered on that edge, so they are due one cycle later. The first `exc_take` is due two cycles after the boundary, and each further exception follows one cycle after the one before. The bench drives on falling edges and steps one falling edge per expected issue. For every scenario that must stay silent, it also watches several cycles in which nothing may be issued.

// File: rtl/trc_seq_pkg.sv
package trc_seq_pkg;
  localparam int NSRC = 4;

  typedef enum logic [1:0] {
    K_FORCED = 2'd0,
    K_TRACE  = 2'd1,
    K_IRQ    = 2'd2,
    K_BKPT   = 2'd3
  } exc_kind_e;

  localparam logic [1:0] TM_OFF  = 2'b00;
  localparam logic [1:0] TM_FLOW = 2'b01;
  localparam logic [1:0] TM_ALL  = 2'b10;
  localparam logic [1:0] TM_RSV  = 2'b11;
endpackage

// File: rtl/trc_qualify.sv
module trc_qualify
  import trc_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       accept,
  input  logic [1:0] trc_mode,
  input  logic       retire_flow,
  input  logic       fault_abort,
  input  logic       rte_fault,
  input  logic       not_executed,
  input  logic       stop_insn,
  output logic       trace_hit,
  output logic       stop_enter,
  output logic       rsv_err
);
  logic completed_ok;
  logic mode_wants;

  // only an instruction that ran to a normal end is traceable
  assign completed_ok = !fault_abort && !rte_fault && !not_executed;

  always_comb begin
    case (trc_mode)
      TM_ALL:  mode_wants = 1'b1;
      TM_FLOW: mode_wants = retire_flow;
      default: mode_wants = 1'b0;   // off and reserved code
    endcase
  end

  assign trace_hit = accept && completed_ok && mode_wants;

  always_ff @(posedge clk) begin
    if (rst) begin
      stop_enter <= 1'b0;
      rsv_err    <= 1'b0;
    end else begin
      stop_enter <= accept && stop_insn && completed_ok && !mode_wants;
      rsv_err    <= accept && (trc_mode == TM_RSV);
    end
  end
endmodule

// File: rtl/trc_pend.sv
module trc_pend
  import trc_seq_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            accept,
  input  logic [NSRC-1:0] req,
  output logic [NSRC-1:0] pend,
  output logic [NSRC-1:0] grant,
  output logic            busy
);
  logic [NSRC:0] above;

  assign above[0] = 1'b0;
  genvar gi;
  generate
    for (gi = 0; gi < NSRC; gi++) begin : g_pick
      // lower index means higher precedence
      assign grant[gi]   = pend[gi] && !above[gi];
      assign above[gi+1] = above[gi] || pend[gi];
    end
  endgenerate

  assign busy = |pend;

  always_ff @(posedge clk) begin
    if (rst)         pend <= '0;
    else if (accept) pend <= req;
    else             pend <= pend & ~grant;
  end

  // R10: exactly one pending exception retires per busy cycle
  assert_one_per_cycle_R10: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($countones(pend) + 1 == $countones($past(pend))));
endmodule

// File: rtl/trc_frame.sv
module trc_frame
  import trc_seq_pkg::*;
#(
  parameter int AW        = 32,
  parameter int VEC_TRACE = 9,
  parameter int VEC_BKPT  = 12,
  parameter int AUTO_BASE = 24,
  parameter int USER_BASE = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            accept,
  input  logic [AW-1:0]   retire_pc,
  input  logic [AW-1:0]   next_pc,
  input  logic [15:0]     sr_in,
  input  logic [7:0]      forced_vec,
  input  logic [2:0]      irq_level,
  input  logic [7:0]      irq_vec,
  input  logic [NSRC-1:0] grant,
  output logic            exc_take,
  output logic [1:0]      exc_kind,
  output logic [7:0]      exc_vec,
  output logic [9:0]      stk_vec_off,
  output logic [AW-1:0]   stk_insn_addr,
  output logic [AW-1:0]   stk_pc,
  output logic [15:0]     stk_sr
);
  localparam logic [7:0] VT = 8'(VEC_TRACE);
  localparam logic [7:0] VB = 8'(VEC_BKPT);
  localparam logic [7:0] VA = 8'(AUTO_BASE);
  localparam logic [7:0] VU = 8'(USER_BASE);

  logic [AW-1:0] s_addr, s_pc;
  logic [15:0]   s_sr;
  logic [7:0]    s_fvec, s_ivec, ivec_now, g_vec;
  exc_kind_e     g_kind;

  assign ivec_now = (irq_vec >= VU) ? irq_vec : (VA + {5'd0, irq_level});

  always_comb begin
    g_kind = K_FORCED;
    for (int i = NSRC - 1; i >= 0; i--)
      if (grant[i]) g_kind = exc_kind_e'(i);
  end

  always_comb begin
    case (g_kind)
      K_FORCED: g_vec = s_fvec;
      K_TRACE:  g_vec = VT;
      K_IRQ:    g_vec = s_ivec;
      default:  g_vec = VB;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s_addr <= '0; s_pc <= '0; s_sr <= '0; s_fvec <= '0; s_ivec <= '0;
      exc_take <= 1'b0; exc_kind <= '0; exc_vec <= '0; stk_vec_off <= '0;
      stk_insn_addr <= '0; stk_pc <= '0; stk_sr <= '0;
    end else begin
      if (accept) begin
        s_addr <= retire_pc;
        s_pc   <= next_pc;
        s_sr   <= sr_in;
        s_fvec <= forced_vec;
        s_ivec <= ivec_now;
      end
      exc_take <= |grant;
      if (|grant) begin
        exc_kind      <= g_kind;
        exc_vec       <= g_vec;
        stk_vec_off   <= {g_vec, 2'b00};
        stk_insn_addr <= s_addr;
        stk_pc        <= s_pc;
        stk_sr        <= s_sr;
      end
    end
  end

  // R7: interrupt vectors land in the user range or on an autovector
  assert_irq_vec_range_R7: assert property (@(posedge clk) disable iff (rst)
    (exc_take && exc_kind == K_IRQ) |->
      (exc_vec >= VU || (exc_vec > VA && exc_vec <= VA + 8'd7)));
endmodule

// File: rtl/trace_exc_seq.sv
module trace_exc_seq
  import trc_seq_pkg::*;
#(
  parameter int AW        = 32,
  parameter int VEC_TRACE = 9,
  parameter int VEC_BKPT  = 12,
  parameter int AUTO_BASE = 24,
  parameter int USER_BASE = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          retire_vld,
  input  logic [AW-1:0] retire_pc,
  input  logic [AW-1:0] next_pc,
  input  logic [15:0]   sr_in,
  input  logic [1:0]    trc_mode,
  input  logic          retire_flow,
  input  logic          forced_exc,
  input  logic [7:0]    forced_vec,
  input  logic          fault_abort,
  input  logic          rte_fault,
  input  logic          not_executed,
  input  logic          stop_insn,
  input  logic [2:0]    irq_level,
  input  logic [7:0]    irq_vec,
  input  logic          bkpt_pend,
  output logic          exc_take,
  output logic [1:0]    exc_kind,
  output logic [7:0]    exc_vec,
  output logic [9:0]    stk_vec_off,
  output logic [AW-1:0] stk_insn_addr,
  output logic [AW-1:0] stk_pc,
  output logic [15:0]   stk_sr,
  output logic          hold_next,
  output logic          stop_enter,
  output logic          trc_rsv_err
);
  logic            accept, trace_hit, busy;
  logic [NSRC-1:0] req, pend_q, grant;

  // boundaries seen while exceptions drain are ignored
  assign accept = retire_vld && !busy;

  trc_qualify u_qual (
    .clk(clk), .rst(rst), .accept(accept), .trc_mode(trc_mode),
    .retire_flow(retire_flow), .fault_abort(fault_abort),
    .rte_fault(rte_fault), .not_executed(not_executed),
    .stop_insn(stop_insn), .trace_hit(trace_hit),
    .stop_enter(stop_enter), .rsv_err(trc_rsv_err)
  );

  always_comb begin
    req           = '0;
    req[K_FORCED] = forced_exc;
    req[K_TRACE]  = trace_hit;
    req[K_IRQ]    = (irq_level != 3'd0);
    req[K_BKPT]   = bkpt_pend;
  end

  trc_pend u_pend (
    .clk(clk), .rst(rst), .accept(accept), .req(req),
    .pend(pend_q), .grant(grant), .busy(busy)
  );

  trc_frame #(
    .AW(AW), .VEC_TRACE(VEC_TRACE), .VEC_BKPT(VEC_BKPT),
    .AUTO_BASE(AUTO_BASE), .USER_BASE(USER_BASE)
  ) u_frame (
    .clk(clk), .rst(rst), .accept(accept), .retire_pc(retire_pc),
    .next_pc(next_pc), .sr_in(sr_in), .forced_vec(forced_vec),
    .irq_level(irq_level), .irq_vec(irq_vec), .grant(grant),
    .exc_take(exc_take), .exc_kind(exc_kind), .exc_vec(exc_vec),
    .stk_vec_off(stk_vec_off), .stk_insn_addr(stk_insn_addr),
    .stk_pc(stk_pc), .stk_sr(stk_sr)
  );

  assign hold_next = busy;

  // R3: reserved code leaves no trace pending
  assert_rsv_no_trace_R3: assert property (@(posedge clk) disable iff (rst)
    trc_rsv_err |-> !pend_q[K_TRACE]);

  // R9: entering stop and a pending trace never coexist
  assert_stop_vs_trace_R9: assert property (@(posedge clk) disable iff (rst)
    stop_enter |-> !pend_q[K_TRACE]);

  // R4: faulted instruction or fault return queues no trace
  assert_fault_untraced_R4: assert property (@(posedge clk) disable iff (rst)
    (accept && (fault_abort || rte_fault)) |=> !pend_q[K_TRACE]);

  // R5: unexecuted instruction queues no trace
  assert_noexec_untraced_R5: assert property (@(posedge clk) disable iff (rst)
    (accept && not_executed) |=> !pend_q[K_TRACE]);

  // R8: nothing of equal or higher precedence remains once one is issued
  assert_priority_R8: assert property (@(posedge clk) disable iff (rst)
    exc_take |-> ((pend_q & ~(4'hF << ({2'b00, exc_kind} + 4'd1))) == 4'h0));
endmodule

// File: tb/trace_exc_seq_test.sv
`timescale 1ns/1ps
module trace_exc_seq_test;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst;
  logic          retire_vld, retire_flow, forced_exc, fault_abort;
  logic          rte_fault, not_executed, stop_insn, bkpt_pend;
  logic [AW-1:0] retire_pc, next_pc;
  logic [15:0]   sr_in;
  logic [1:0]    trc_mode;
  logic [7:0]    forced_vec, irq_vec;
  logic [2:0]    irq_level;
  logic          exc_take, hold_next, stop_enter, trc_rsv_err;
  logic [1:0]    exc_kind;
  logic [7:0]    exc_vec;
  logic [9:0]    stk_vec_off;
  logic [AW-1:0] stk_insn_addr, stk_pc;
  logic [15:0]   stk_sr;

  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk = ~clk;

  trace_exc_seq uut (
    .clk(clk), .rst(rst), .retire_vld(retire_vld), .retire_pc(retire_pc),
    .next_pc(next_pc), .sr_in(sr_in), .trc_mode(trc_mode),
    .retire_flow(retire_flow), .forced_exc(forced_exc),
    .forced_vec(forced_vec), .fault_abort(fault_abort),
    .rte_fault(rte_fault), .not_executed(not_executed),
    .stop_insn(stop_insn), .irq_level(irq_level), .irq_vec(irq_vec),
    .bkpt_pend(bkpt_pend), .exc_take(exc_take), .exc_kind(exc_kind),
    .exc_vec(exc_vec), .stk_vec_off(stk_vec_off),
    .stk_insn_addr(stk_insn_addr), .stk_pc(stk_pc), .stk_sr(stk_sr),
    .hold_next(hold_next), .stop_enter(stop_enter),
    .trc_rsv_err(trc_rsv_err)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clear_in();
    retire_vld = 0; retire_flow = 0; forced_exc = 0; fault_abort = 0;
    rte_fault = 0; not_executed = 0; stop_insn = 0; bkpt_pend = 0;
    forced_vec = 0; irq_vec = 0; irq_level = 0;
  endtask

  // present a boundary at the current falling edge; return one cycle later
  task automatic retire(input logic [31:0] pc, input logic [31:0] npc,
                        input logic [15:0] sr);
    retire_pc = pc; next_pc = npc; sr_in = sr; retire_vld = 1;
    @(posedge clk);
    @(negedge clk);
    clear_in();
  endtask

  task automatic expect_take(input string req, input logic [1:0] kind,
                             input logic [7:0] vec, input logic [31:0] pc,
                             input logic [31:0] npc, input logic [15:0] sr);
    @(negedge clk);
    chk(req, "exc_take", exc_take, 1);
    chk(req, "exc_kind", exc_kind, kind);
    chk(req, "exc_vec", exc_vec, vec);
    chk(req, "stk_vec_off", stk_vec_off, {22'd0, vec, 2'b00});
    chk(req, "stk_insn_addr", stk_insn_addr, pc);
    chk(req, "stk_pc", stk_pc, npc);
    chk(req, "stk_sr", stk_sr, sr);
  endtask

  task automatic expect_quiet(input string req, input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      chk(req, "exc_take idle", exc_take, 0);
      chk(req, "hold_next idle", hold_next, 0);
    end
  endtask

  task automatic t_reset();
    chk("R1", "exc_take", exc_take, 0);
    chk("R1", "hold_next", hold_next, 0);
    chk("R1", "stop_enter", stop_enter, 0);
    chk("R1", "trc_rsv_err", trc_rsv_err, 0);
  endtask

  task automatic t_modes();
    trc_mode = 2'b10;
    retire(32'h100, 32'h104, 16'h8000);
    chk("R2", "hold after boundary", hold_next, 1);
    chk("R2", "no early take", exc_take, 0);
    expect_take("R2", 2'b01, 8'd9, 32'h100, 32'h104, 16'h8000);
    chk("R10", "hold drops at last issue", hold_next, 0);
    expect_quiet("R2", 2);
    trc_mode = 2'b01;
    retire(32'h200, 32'h202, 16'h4000);
    expect_quiet("R2", 3);
    retire_flow = 1;
    retire(32'h210, 32'h300, 16'h4001);
    expect_take("R2", 2'b01, 8'd9, 32'h210, 32'h300, 16'h4001);
    trc_mode = 2'b00; retire_flow = 1;
    retire(32'h220, 32'h224, 16'h0);
    expect_quiet("R2", 3);
  endtask

  task automatic t_reserved();
    trc_mode = 2'b11; retire_flow = 1;
    retire(32'h400, 32'h404, 16'hC000);
    chk("R3", "trc_rsv_err", trc_rsv_err, 1);
    @(negedge clk);
    chk("R3", "trc_rsv_err one cycle", trc_rsv_err, 0);
    chk("R3", "no trace", exc_take, 0);
    expect_quiet("R3", 2);
  endtask

  task automatic t_fault();
    trc_mode = 2'b10;
    fault_abort = 1;
    retire(32'h500, 32'h504, 16'h8000);
    expect_quiet("R4", 3);
    rte_fault = 1;
    retire(32'h600, 32'h500, 16'h8000);
    expect_quiet("R4", 3);
    retire(32'h500, 32'h504, 16'h8000);
    expect_take("R4", 2'b01, 8'd9, 32'h500, 32'h504, 16'h8000);
  endtask

  task automatic t_noexec();
    trc_mode = 2'b10;
    not_executed = 1; forced_exc = 1; forced_vec = 8'd4;
    retire(32'h700, 32'h702, 16'h8000);
    expect_take("R5", 2'b00, 8'd4, 32'h700, 32'h702, 16'h8000);
    expect_quiet("R5", 2);
  endtask

  task automatic t_forced();
    trc_mode = 2'b10; forced_exc = 1; forced_vec = 8'd32;
    retire(32'h800, 32'h802, 16'h8700);
    expect_take("R6", 2'b00, 8'd32, 32'h800, 32'h802, 16'h8700);
    expect_take("R6", 2'b01, 8'd9, 32'h800, 32'h802, 16'h8700);
    expect_quiet("R6", 1);
  endtask

  task automatic t_irq();
    trc_mode = 2'b10; irq_level = 3'd5; irq_vec = 8'h40;
    retire(32'h900, 32'h904, 16'h8000);
    expect_take("R7", 2'b01, 8'd9, 32'h900, 32'h904, 16'h8000);
    expect_take("R7", 2'b10, 8'h40, 32'h900, 32'h904, 16'h8000);
    trc_mode = 2'b00; irq_level = 3'd3; irq_vec = 8'd10;
    retire(32'h910, 32'h914, 16'h2000);
    expect_take("R7", 2'b10, 8'd27, 32'h910, 32'h914, 16'h2000);
    expect_quiet("R7", 1);
  endtask

  task automatic t_bkpt();
    trc_mode = 2'b10; irq_level = 3'd7; irq_vec = 8'd200; bkpt_pend = 1;
    retire(32'hA00, 32'hA04, 16'h8000);
    expect_take("R8", 2'b01, 8'd9, 32'hA00, 32'hA04, 16'h8000);
    expect_take("R8", 2'b10, 8'd200, 32'hA00, 32'hA04, 16'h8000);
    expect_take("R8", 2'b11, 8'd12, 32'hA00, 32'hA04, 16'h8000);
    forced_exc = 1; forced_vec = 8'd33; irq_level = 3'd1; irq_vec = 8'd0;
    bkpt_pend = 1;
    retire(32'hA10, 32'hA12, 16'h8100);
    expect_take("R8", 2'b00, 8'd33, 32'hA10, 32'hA12, 16'h8100);
    expect_take("R8", 2'b01, 8'd9, 32'hA10, 32'hA12, 16'h8100);
    expect_take("R8", 2'b10, 8'd25, 32'hA10, 32'hA12, 16'h8100);
    expect_take("R8", 2'b11, 8'd12, 32'hA10, 32'hA12, 16'h8100);
    expect_quiet("R8", 1);
  endtask

  task automatic t_stop();
    trc_mode = 2'b10; stop_insn = 1;
    retire(32'hB00, 32'hB04, 16'h8000);
    chk("R9", "no stop when traced", stop_enter, 0);
    expect_take("R9", 2'b01, 8'd9, 32'hB00, 32'hB04, 16'h8000);
    chk("R9", "still no stop", stop_enter, 0);
    trc_mode = 2'b00; stop_insn = 1;
    retire(32'hB10, 32'hB14, 16'h2000);
    chk("R9", "stop_enter pulse", stop_enter, 1);
    @(negedge clk);
    chk("R9", "stop_enter one cycle", stop_enter, 0);
  endtask

  task automatic t_busy();
    trc_mode = 2'b10; forced_exc = 1; forced_vec = 8'd40; irq_level = 3'd2;
    retire(32'hC00, 32'hC04, 16'h8000);
    retire_vld = 1; retire_pc = 32'hD00; next_pc = 32'hD04; sr_in = 16'h8001;
    expect_take("R10", 2'b00, 8'd40, 32'hC00, 32'hC04, 16'h8000);
    chk("R10", "hold mid drain", hold_next, 1);
    expect_take("R10", 2'b01, 8'd9, 32'hC00, 32'hC04, 16'h8000);
    expect_take("R10", 2'b10, 8'd26, 32'hC00, 32'hC04, 16'h8000);
    retire_vld = 0;
    chk("R10", "hold at last issue", hold_next, 0);
    expect_quiet("R10", 2);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    clear_in();
    retire_pc = 0; next_pc = 0; sr_in = 0; trc_mode = 0;
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    t_reset();
    t_modes();
    t_reserved();
    t_fault();
    t_noexec();
    t_forced();
    t_irq();
    t_bkpt();
    t_stop();
    t_busy();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule